// File: doc/BRIEF.md
# Burst-Mode Laser Power Control Loop

This block runs the digital power regulation of a burst-mode laser transmitter. For each burst requested by the media access controller it switches the laser on and sends a short all-ones power field. It then passes data until the controller flags the last data cycle. If the controller asks for it on that cycle, it sends a trailing all-zeros control field before switching the laser off. Inside each power field the block raises a single strobe to the monitor-photodiode ADC. The strobe comes after a programmable settle delay, and the sample is captured on that cycle.

When the laser turns off, the captured levels move the two drive codes by at most one step each. The bias code moves so that the zero-level reading approaches its target. The modulation code moves so that the measured swing (one reading minus zero reading) approaches the one-level target minus the zero-level target. The codes sit in registers between bursts and drive the laser from the first lit cycle of the next burst. The next burst therefore starts at the learned operating point and does not need to settle again.

The field lengths and the settle delay are counts of clock cycles (bit times). Every length must be at least 1, and the settle delay must be less than each field length.

Top module: `burst_power_ctrl`

## Requirements
- R1: During and right after reset, `tx_on` is 0, `drive_field` is 0 (idle), `adc_strobe` is 0, `bias_code` equals the BIAS_INIT parameter (60) and `mod_code` equals the MOD_INIT parameter (4).
- R2: When `burst_req` is high in an idle cycle, `tx_on` rises the next cycle. `drive_field` is then 1 (all-ones field) for exactly `ones_len` cycles, and then 2 (data) up to and including the cycle in which `data_end` is high.
- R3: If `ctl_en` is high in the `data_end` cycle, `drive_field` is 3 (all-zeros field) for exactly `zero_len` cycles and then `tx_on` falls. Otherwise `tx_on` falls in the cycle right after `data_end`.
- R4: `adc_strobe` is high exactly once in each all-ones or all-zeros field, `settle_dly` cycles after that field's first cycle (0 means the first cycle). It is never high in data or idle cycles.
- R5: After a burst that included the all-zeros field, `bias_code` goes up by 1 if the zero-field sample was below `zero_target`, down by 1 if it was above, and stays the same if they were equal. The new value is visible in the second cycle after the last cycle with `tx_on` high.
- R6: After a burst that included the all-zeros field, `mod_code` goes up by 1 if (one sample − zero sample) < (`one_target` − `zero_target`), down by 1 if it was greater, and stays the same if they were equal. The values are compared as signed numbers, and the update appears in the same cycle as R5.
- R7: Both codes saturate: a step up from 2^CODE_W−1 (63) and a step down from 0 leave the code unchanged.
- R8: A burst without the all-zeros field leaves both codes unchanged.
- R9: While `tx_on` is high the codes do not change. At the first lit cycle they equal the values stored after the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_req | input | 1 | Burst request from the MAC, sampled when idle |
| data_end | input | 1 | High in the last data cycle of the burst |
| ctl_en | input | 1 | Requests the trailing all-zeros field, sampled with data_end |
| adc_data | input | ADC_W | Monitor photodiode ADC reading |
| one_target | input | ADC_W | Target reading for the one level |
| zero_target | input | ADC_W | Target reading for the zero level |
| ones_len | input | LEN_W | Length of the all-ones field in cycles |
| zero_len | input | LEN_W | Length of the all-zeros field in cycles |
| settle_dly | input | LEN_W | Cycles from field start to ADC strobe |
| tx_on | output | 1 | Laser enable |
| drive_field | output | 2 | Current field: 0 idle, 1 ones, 2 data, 3 zeros |
| adc_strobe | output | 1 | ADC sample strobe; the sample is taken in this cycle |
| bias_code | output | CODE_W | Stored bias drive code |
| mod_code | output | CODE_W | Stored modulation drive code |

## Verification
`tx_on` rises one cycle after an accepted request, and the strobe is due `settle_dly` cycles into each power field. The codes change at the clock edge that ends the first dark cycle, so they are compared in the cycle after `tx_on` falls. The monitor samples on the falling clock edge. It counts field cycles from the rising edge of `tx_on` and measures the strobe position from each field boundary it sees. The driver pushes the expected codes for each burst into a queue before it raises the request. On each rising edge of `tx_on` the monitor pops one entry and checks the codes at the burst start (R9). It checks the updated codes one cycle after `tx_on` falls.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        FLD_IDLE = 2'd0,
        FLD_ONES = 2'd1,
        FLD_DATA = 2'd2,
        FLD_ZERO = 2'd3
    } field_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ONES,
        ST_DATA,
        ST_ZERO,
        ST_OFF
    } seq_state_t;

    typedef enum logic [1:0] {
        DIR_HOLD,
        DIR_UP,
        DIR_DOWN
    } step_dir_t;

    function automatic step_dir_t dir_from_cmp(input logic below, input logic above);
        if (below)      return DIR_UP;
        else if (above) return DIR_DOWN;
        else            return DIR_HOLD;
    endfunction

endpackage

// File: rtl/bpc_burst_seq.sv
module bpc_burst_seq
    import bpc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_req,
    input  logic             data_end,
    input  logic             ctl_en,
    input  logic [LEN_W-1:0] ones_len,
    input  logic [LEN_W-1:0] zero_len,
    input  logic [LEN_W-1:0] settle_dly,
    output field_t           field,
    output logic             tx_on,
    output logic             strobe,
    output logic             burst_start,
    output logic             burst_done
);

    seq_state_t       state;
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (burst_req) state <= ST_ONES;
                end
                ST_ONES: begin
                    if (cnt == ones_len - 1'b1) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    cnt <= '0;
                    if (data_end) state <= ctl_en ? ST_ZERO : ST_OFF;
                end
                ST_ZERO: begin
                    if (cnt == zero_len - 1'b1) begin
                        state <= ST_OFF;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_ONES: field = FLD_ONES;
            ST_DATA: field = FLD_DATA;
            ST_ZERO: field = FLD_ZERO;
            default: field = FLD_IDLE;
        endcase
    end

    assign tx_on       = (state == ST_ONES) || (state == ST_DATA) || (state == ST_ZERO);
    assign strobe      = ((state == ST_ONES) || (state == ST_ZERO)) && (cnt == settle_dly);
    assign burst_start = (state == ST_IDLE) && burst_req;
    assign burst_done  = (state == ST_OFF);

endmodule

// File: rtl/bpc_level_capture.sv
module bpc_level_capture
    import bpc_pkg::*;
#(
    parameter int ADC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    input  field_t           field,
    input  logic [ADC_W-1:0] adc_data,
    output logic [ADC_W-1:0] one_smp,
    output logic [ADC_W-1:0] zero_smp,
    output logic             one_vld,
    output logic             zero_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            one_smp  <= '0;
            zero_smp <= '0;
            one_vld  <= 1'b0;
            zero_vld <= 1'b0;
        end else if (clear) begin
            one_vld  <= 1'b0;
            zero_vld <= 1'b0;
        end else if (strobe) begin
            if (field == FLD_ONES) begin
                one_smp <= adc_data;
                one_vld <= 1'b1;
            end
            if (field == FLD_ZERO) begin
                zero_smp <= adc_data;
                zero_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bpc_code_stepper.sv
module bpc_code_stepper
    import bpc_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int INIT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  step_dir_t         dir,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CODE_RST;
        end else if (apply) begin
            if (dir == DIR_UP && code != CODE_MAX)
                code <= code + 1'b1;
            else if (dir == DIR_DOWN && code != '0)
                code <= code - 1'b1;
        end
    end

endmodule

// File: rtl/burst_power_ctrl.sv
module burst_power_ctrl
    import bpc_pkg::*;
#(
    parameter int ADC_W     = 8,
    parameter int CODE_W    = 6,
    parameter int LEN_W     = 8,
    parameter int BIAS_INIT = 60,
    parameter int MOD_INIT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_req,
    input  logic              data_end,
    input  logic              ctl_en,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic [ADC_W-1:0]  one_target,
    input  logic [ADC_W-1:0]  zero_target,
    input  logic [LEN_W-1:0]  ones_len,
    input  logic [LEN_W-1:0]  zero_len,
    input  logic [LEN_W-1:0]  settle_dly,
    output logic              tx_on,
    output logic [1:0]        drive_field,
    output logic              adc_strobe,
    output logic [CODE_W-1:0] bias_code,
    output logic [CODE_W-1:0] mod_code
);

    localparam int DIFF_W  = ADC_W + 1;
    localparam int N_LOOPS = 2;

    field_t           field;
    logic             burst_start;
    logic             burst_done;
    logic [ADC_W-1:0] one_smp;
    logic [ADC_W-1:0] zero_smp;
    logic             one_vld;
    logic             zero_vld;

    bpc_burst_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .burst_req   (burst_req),
        .data_end    (data_end),
        .ctl_en      (ctl_en),
        .ones_len    (ones_len),
        .zero_len    (zero_len),
        .settle_dly  (settle_dly),
        .field       (field),
        .tx_on       (tx_on),
        .strobe      (adc_strobe),
        .burst_start (burst_start),
        .burst_done  (burst_done)
    );

    bpc_level_capture #(.ADC_W(ADC_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clear    (burst_start),
        .strobe   (adc_strobe),
        .field    (field),
        .adc_data (adc_data),
        .one_smp  (one_smp),
        .zero_smp (zero_smp),
        .one_vld  (one_vld),
        .zero_vld (zero_vld)
    );

    logic signed [DIFF_W-1:0] swing_meas;
    logic signed [DIFF_W-1:0] swing_tgt;

    assign swing_meas = $signed({1'b0, one_smp}) - $signed({1'b0, zero_smp});
    assign swing_tgt  = $signed({1'b0, one_target}) - $signed({1'b0, zero_target});

    step_dir_t         loop_dir   [N_LOOPS];
    logic              loop_apply [N_LOOPS];
    logic [CODE_W-1:0] loop_code  [N_LOOPS];

    // loop 0: bias follows zero-level error; loop 1: modulation follows swing error
    assign loop_dir[0]   = dir_from_cmp(zero_smp < zero_target, zero_smp > zero_target);
    assign loop_dir[1]   = dir_from_cmp(swing_meas < swing_tgt, swing_meas > swing_tgt);
    assign loop_apply[0] = burst_done && zero_vld;
    assign loop_apply[1] = burst_done && zero_vld && one_vld;

    genvar g;
    generate
        for (g = 0; g < N_LOOPS; g++) begin : g_loop
            bpc_code_stepper #(
                .CODE_W (CODE_W),
                .INIT   ((g == 0) ? BIAS_INIT : MOD_INIT)
            ) u_step (
                .clk   (clk),
                .rst   (rst),
                .apply (loop_apply[g]),
                .dir   (loop_dir[g]),
                .code  (loop_code[g])
            );
        end
    endgenerate

    assign bias_code   = loop_code[0];
    assign mod_code    = loop_code[1];
    assign drive_field = field;

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_on,
    input logic [1:0]        drive_field,
    input logic              adc_strobe,
    input logic [CODE_W-1:0] bias_code,
    input logic [CODE_W-1:0] mod_code
);

    assert_strobe_in_field_R4: assert property (@(posedge clk) disable iff (rst)
        adc_strobe |-> (drive_field == 2'd1 || drive_field == 2'd3));

    assert_rise_ones_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_on) |-> drive_field == 2'd1);

    assert_fall_after_data_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_on) |-> ($past(drive_field) == 2'd2 || $past(drive_field) == 2'd3));

    assert_codes_held_R9: assert property (@(posedge clk) disable iff (rst)
        tx_on |-> ($stable(bias_code) && $stable(mod_code)));

    assert_bias_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(bias_code) |->
            (int'(bias_code) == int'($past(bias_code)) + 1 ||
             int'(bias_code) == int'($past(bias_code)) - 1));

    assert_mod_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mod_code) |->
            (int'(mod_code) == int'($past(mod_code)) + 1 ||
             int'(mod_code) == int'($past(mod_code)) - 1));

endmodule

bind burst_power_ctrl bpc_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_on       (tx_on),
    .drive_field (drive_field),
    .adc_strobe  (adc_strobe),
    .bias_code   (bias_code),
    .mod_code    (mod_code)
);

// File: tb/tb_burst_power_ctrl.sv
`timescale 1ns/1ps
module tb_burst_power_ctrl;

    localparam int ADC_W = 8;
    localparam int CODE_W = 6;
    localparam int LEN_W = 8;
    localparam int CMAX = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_req = 1'b0;
    logic data_end = 1'b0;
    logic ctl_en = 1'b0;
    logic [ADC_W-1:0] adc_data;
    logic [ADC_W-1:0] one_target = 8'd50;
    logic [ADC_W-1:0] zero_target = 8'd20;
    logic [LEN_W-1:0] ones_len = 8'd6;
    logic [LEN_W-1:0] zero_len = 8'd8;
    logic [LEN_W-1:0] settle_dly = 8'd3;
    logic tx_on;
    logic [1:0] drive_field;
    logic adc_strobe;
    logic [CODE_W-1:0] bias_code;
    logic [CODE_W-1:0] mod_code;

    always #5 clk = ~clk;

    // plant model: zero level reads as bias, one level as bias + modulation
    assign adc_data = (drive_field == 2'd1) ? ADC_W'(bias_code) + ADC_W'(mod_code) :
                      (drive_field == 2'd3) ? ADC_W'(bias_code) : '0;

    burst_power_ctrl dut (
        .clk(clk), .rst(rst), .burst_req(burst_req), .data_end(data_end),
        .ctl_en(ctl_en), .adc_data(adc_data), .one_target(one_target),
        .zero_target(zero_target), .ones_len(ones_len), .zero_len(zero_len),
        .settle_dly(settle_dly), .tx_on(tx_on), .drive_field(drive_field),
        .adc_strobe(adc_strobe), .bias_code(bias_code), .mod_code(mod_code)
    );

    typedef struct {
        int    pre_b;
        int    pre_m;
        int    post_b;
        int    post_m;
        int    dlen;
        bit    ctl;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int mb = 60;
    int mm = 4;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int step(input int c, input int meas, input int tgt);
        if (meas < tgt && c < CMAX) return c + 1;
        if (meas > tgt && c > 0) return c - 1;
        return c;
    endfunction

    task automatic run_burst(input int dlen, input bit ctl, input string tag);
        exp_t e;
        e.pre_b = mb;
        e.pre_m = mm;
        e.dlen  = dlen;
        e.ctl   = ctl;
        e.tag   = tag;
        if (ctl) begin
            mb = step(e.pre_b, e.pre_b, int'(zero_target));
            mm = step(e.pre_m, e.pre_m, int'(one_target) - int'(zero_target));
        end
        e.post_b = mb;
        e.post_m = mm;
        exp_q.push_back(e);
        @(negedge clk) burst_req = 1'b1;
        @(negedge clk) burst_req = 1'b0;
        while (drive_field != 2'd2) @(negedge clk);
        repeat (dlen - 1) @(negedge clk);
        data_end = 1'b1;
        ctl_en   = ctl;
        @(negedge clk);
        data_end = 1'b0;
        ctl_en   = 1'b0;
        while (tx_on) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor
    exp_t cur;
    bit prev_on = 1'b0;
    bit post = 1'b0;
    int n_ones, n_data, n_zero, n_strb, fcnt;
    logic [1:0] pf;

    always @(negedge clk) begin
        if (rst) begin
            prev_on = 1'b0;
            post = 1'b0;
        end else begin
            if (adc_strobe && !tx_on)
                chk(1'b0, "R4 strobe while dark", 1, 0);
            if (tx_on && !prev_on) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected burst", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                end
                chk(int'(bias_code) == cur.pre_b, "R9 bias at burst start", int'(bias_code), cur.pre_b);
                chk(int'(mod_code) == cur.pre_m, "R9 mod at burst start", int'(mod_code), cur.pre_m);
                chk(drive_field == 2'd1, "R2 first lit field", int'(drive_field), 1);
                n_ones = 0; n_data = 0; n_zero = 0; n_strb = 0; fcnt = 0;
                pf = drive_field;
            end else if (tx_on) begin
                fcnt = (drive_field == pf) ? fcnt + 1 : 0;
                pf = drive_field;
            end
            if (tx_on) begin
                case (drive_field)
                    2'd1: n_ones++;
                    2'd2: n_data++;
                    2'd3: n_zero++;
                    default: chk(1'b0, "R2 idle field while lit", 0, 1);
                endcase
                if (adc_strobe) begin
                    n_strb++;
                    chk(fcnt == int'(settle_dly), "R4 strobe offset", fcnt, int'(settle_dly));
                end
            end
            if (!tx_on && prev_on) begin
                chk(n_ones == int'(ones_len), "R2 ones field length", n_ones, int'(ones_len));
                chk(n_data == cur.dlen, "R2 data length", n_data, cur.dlen);
                chk(n_zero == (cur.ctl ? int'(zero_len) : 0), "R3 zeros field length",
                    n_zero, cur.ctl ? int'(zero_len) : 0);
                chk(n_strb == (cur.ctl ? 2 : 1), "R4 strobe count", n_strb, cur.ctl ? 2 : 1);
                post = 1'b1;
            end else if (post) begin
                post = 1'b0;
                chk(int'(bias_code) == cur.post_b, {cur.tag, " bias after burst"},
                    int'(bias_code), cur.post_b);
                chk(int'(mod_code) == cur.post_m, {cur.tag, " mod after burst"},
                    int'(mod_code), cur.post_m);
            end
            prev_on = tx_on;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_on == 1'b0, "R1 tx_on in reset", int'(tx_on), 0);
        chk(int'(bias_code) == 60, "R1 bias in reset", int'(bias_code), 60);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_on == 1'b0, "R1 tx_on after reset", int'(tx_on), 0);
        chk(drive_field == 2'd0, "R1 field after reset", int'(drive_field), 0);
        chk(adc_strobe == 1'b0, "R1 strobe after reset", int'(adc_strobe), 0);
        chk(int'(bias_code) == 60, "R1 bias after reset", int'(bias_code), 60);
        chk(int'(mod_code) == 4, "R1 mod after reset", int'(mod_code), 4);

        run_burst(5, 1'b0, "R8");
        for (int i = 0; i < 4; i++) run_burst(4 + i, 1'b1, "R5/R6");
        run_burst(2, 1'b0, "R8");

        ones_len = 8'd1; zero_len = 8'd2; settle_dly = 8'd0;
        run_burst(1, 1'b1, "R5/R6 min fields");
        run_burst(3, 1'b1, "R5/R6 min fields");

        ones_len = 8'd8; zero_len = 8'd10; settle_dly = 8'd7;
        run_burst(2, 1'b1, "R5/R6 late strobe");
        run_burst(6, 1'b1, "R5/R6 late strobe");

        ones_len = 8'd4; zero_len = 8'd5; settle_dly = 8'd2;
        zero_target = 8'd0;
        for (int i = 0; i < 60; i++) run_burst(2, 1'b1, "R7 floor");

        zero_target = 8'd200; one_target = 8'd100;
        for (int i = 0; i < 70; i++) run_burst(2, 1'b1, "R7 ceiling");

        zero_target = 8'd63; one_target = 8'd63;
        run_burst(3, 1'b1, "R5 hold");
        run_burst(3, 1'b1, "R5 hold");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule